// File: doc/BRIEF.md
# Flash Program/Erase Polling Sequencer

This block sits on the host side of a flash memory segment and runs a full write operation on the host's behalf. On a start request it takes an operation type (program a run of bytes, erase one sector, or erase a whole segment) and a target address. It then issues the unlock and command bus writes the segment expects. After a fixed recovery gap it polls the target location until status bit 7 reports that the internal operation has finished.

Completion is found on bit 7 alone. A programmed byte shows the inverse of its written bit 7 while busy, and an erased location reads bit 7 low until it is erased. Bit 7 can settle before the rest of the byte, so the sequencer reads the location once more and compares the whole byte. Every poll re-drives the target address. A multi-byte program walks consecutive addresses, each with its own command sequence and its own poll. The outcome is a single done pulse with a verify-error or timeout flag.

The bus is a plain synchronous strobe bus. A write takes one cycle with `bus_wr` high. A read strobe `bus_rd` lasts one cycle, and the responder returns `bus_rdata` in the following cycle. The byte data to program is fetched through `buf_idx`/`buf_data`, and the host holds `buf_data` valid for the current `buf_idx` while the block is busy.

Top module: `flash_poll_seq`

## Requirements
- R1: After reset, `busy`, `done`, `bus_wr`, `bus_rd`, `err_verify` and `err_timeout` are all low.
- R2: A program operation (op code 0) issues four writes on consecutive cycles, starting the cycle after start is accepted, for each byte. The writes are AAh to segment base + AAAAh, 55h to base + 5554h, A0h to base + AAAAh, and then the byte data to the byte's own address. The segment base is the byte address with its low SEG_W bits cleared.
- R3: A sector erase (op code 1) issues six consecutive writes: AAh, 55h and 80h, then AAh and 55h on the same two unlock addresses, and finally 30h to the target address. A segment erase (op code 2) ends instead with 10h to base + AAAAh.
- R4: No read strobe occurs during a command burst. The first read after the last write of a burst comes exactly RECOV_CYC+2 cycles after that write.
- R5: Every read strobe carries the current target address: the byte being programmed, or the erase target address.
- R6: A poll counts as complete when read bit 7 equals bit 7 of the written byte (program) or is 1 (erase). An incomplete poll is followed by the next read strobe two cycles after the previous one.
- R7: After bit 7 completes, one more read is made. Its whole byte must equal the written byte (program) or FFh (erase). Otherwise the operation ends with `err_verify` set.
- R8: A program of `len_m1`+1 bytes writes and verifies each byte at consecutive addresses starting at `base_addr`. It raises done only after the last byte.
- R9: After POLL_MAX incomplete polls of one byte, the operation ends with `err_timeout` set and no further read.
- R10: `done` is a one-cycle pulse two cycles after the final read strobe, with `busy` high in that cycle and low after it. The error flags are valid in the done cycle, hold until the next accepted start, and are cleared by that start.
- R11: A start while busy, or a start with op code 3, is ignored: it causes no bus write and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle |
| op | input | 2 | 0 program, 1 sector erase, 2 segment erase, 3 reserved |
| base_addr | input | ADDR_W | First byte address or erase target |
| len_m1 | input | LEN_W | Number of bytes to program minus one |
| buf_idx | output | LEN_W | Index of the byte currently programmed |
| buf_data | input | 8 | Data byte for `buf_idx` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_verify | output | 1 | Final byte compare failed |
| err_timeout | output | 1 | Poll limit reached |
| bus_wr | output | 1 | Bus write strobe |
| bus_rd | output | 1 | Bus read strobe |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |

## Verification
Each result has a fixed due cycle. The first command write appears one cycle after the start is accepted, and the writes follow back to back. The first poll strobe comes RECOV_CYC+2 cycles after the last write, re-polls come every two cycles, and `done` comes two cycles after the last read strobe. The bench counts falling edges from reset and samples every output there, half a cycle away from the edge that changes it. It compares each strobe against a behavioural expectation queue, checks the gap and done spacing as exact cycle differences, and checks the read count against a count derived from the responder's scaled busy time.

// File: rtl/fps_pkg.sv
package fps_pkg;

   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_SECT = 2'd1,
      OP_SEG  = 2'd2
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_GAP,
      ST_RD,
      ST_RW,
      ST_FIN
   } st_e;

   localparam logic [7:0] CMD_UNLK1 = 8'hAA;
   localparam logic [7:0] CMD_UNLK2 = 8'h55;
   localparam logic [7:0] CMD_PROG  = 8'hA0;
   localparam logic [7:0] CMD_ERSET = 8'h80;
   localparam logic [7:0] CMD_SECT  = 8'h30;
   localparam logic [7:0] CMD_SEG   = 8'h10;
   localparam logic [7:0] ERASED_B  = 8'hFF;

   localparam int PROG_STEPS  = 4;
   localparam int ERASE_STEPS = 6;

endpackage

// File: rtl/fps_cmd_gen.sv
module fps_cmd_gen
   import fps_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int SEG_W   = 19,
   parameter int UNLK_A1 = 'hAAAA,
   parameter int UNLK_A2 = 'h5554
)(
   input  op_e               op,
   input  logic [2:0]        step,
   input  logic [ADDR_W-1:0] tgt,
   input  logic [7:0]        pdata,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [7:0]        cmd_data,
   output logic              cmd_last
);
   localparam logic [ADDR_W-1:0] SEG_MASK = ~((ADDR_W'(1) << SEG_W) - ADDR_W'(1));
   localparam logic [ADDR_W-1:0] OFS_A1   = ADDR_W'(UNLK_A1);
   localparam logic [ADDR_W-1:0] OFS_A2   = ADDR_W'(UNLK_A2);

   logic [ADDR_W-1:0] seg_base;
   logic [ADDR_W-1:0] a1, a2;
   logic              is_prog;

   assign seg_base = tgt & SEG_MASK;
   assign a1       = seg_base | OFS_A1;
   assign a2       = seg_base | OFS_A2;
   assign is_prog  = (op == OP_PROG);

   always_comb begin
      cmd_addr = a1;
      cmd_data = CMD_UNLK1;
      unique case (step)
         3'd0: begin cmd_addr = a1; cmd_data = CMD_UNLK1; end
         3'd1: begin cmd_addr = a2; cmd_data = CMD_UNLK2; end
         3'd2: begin cmd_addr = a1; cmd_data = is_prog ? CMD_PROG : CMD_ERSET; end
         3'd3: begin
            cmd_addr = is_prog ? tgt   : a1;
            cmd_data = is_prog ? pdata : CMD_UNLK1;
         end
         3'd4: begin cmd_addr = a2; cmd_data = CMD_UNLK2; end
         3'd5: begin
            cmd_addr = (op == OP_SECT) ? tgt      : a1;
            cmd_data = (op == OP_SECT) ? CMD_SECT : CMD_SEG;
         end
         default: begin cmd_addr = a1; cmd_data = CMD_UNLK1; end
      endcase
   end

   assign cmd_last = is_prog ? (step == 3'(PROG_STEPS - 1))
                             : (step == 3'(ERASE_STEPS - 1));

endmodule

// File: rtl/fps_gap_timer.sv
module fps_gap_timer #(
   parameter int CYC = 600
)(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int CNT_W = (CYC < 1) ? 1 : $clog2(CYC + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= CNT_W'(CYC);
      else if (cnt != '0)
         cnt <= cnt - CNT_W'(1);
   end

   assign expired = (cnt == '0);

   // R4: a freshly loaded gap must not report expiry on the next cycle
   p_gap_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (CYC > 0)) |=> !expired);

endmodule

// File: rtl/fps_poll_judge.sv
module fps_poll_judge
   import fps_pkg::*;
(
   input  op_e        op,
   input  logic [7:0] pdata,
   input  logic [7:0] rdata,
   output logic       bit7_ok,
   output logic       byte_ok
);
   logic [7:0] want;

   assign want    = (op == OP_PROG) ? pdata : ERASED_B;
   assign bit7_ok = (rdata[7] == want[7]);
   assign byte_ok = (rdata == want);

endmodule

// File: rtl/flash_poll_seq.sv
module flash_poll_seq
   import fps_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int SEG_W     = 19,
   parameter int LEN_W     = 8,
   parameter int RECOV_CYC = 600,
   parameter int POLL_MAX  = 1024,
   parameter int UNLK_A1   = 'hAAAA,
   parameter int UNLK_A2   = 'h5554
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [LEN_W-1:0]  len_m1,
   output logic [LEN_W-1:0]  buf_idx,
   input  logic [7:0]        buf_data,
   output logic              busy,
   output logic              done,
   output logic              err_verify,
   output logic              err_timeout,
   output logic              bus_wr,
   output logic              bus_rd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [7:0]        bus_wdata,
   input  logic [7:0]        bus_rdata
);
   localparam int PC_W = $clog2(POLL_MAX + 1);

   generate
      if (SEG_W < 16 || SEG_W >= ADDR_W) begin : g_bad_seg
         $error("SEG_W must cover the unlock offsets and stay below ADDR_W");
      end
      if (POLL_MAX < 1) begin : g_bad_poll
         $error("POLL_MAX must be at least 1");
      end
      if (RECOV_CYC < 0) begin : g_bad_gap
         $error("RECOV_CYC must not be negative");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("LEN_W must be at least 1");
      end
   endgenerate

   st_e               st;
   op_e               op_q;
   logic [ADDR_W-1:0] tgt;
   logic [LEN_W-1:0]  idx, len_q;
   logic [2:0]        step;
   logic              confirm;
   logic [PC_W-1:0]   poll_cnt;
   logic              err_v, err_t;

   logic [ADDR_W-1:0] cmd_addr;
   logic [7:0]        cmd_data;
   logic              cmd_last;
   logic              gap_load, gap_expired;
   logic              bit7_ok, byte_ok;
   logic              op_ok;

   assign op_ok = (op != 2'd3);

   fps_cmd_gen #(
      .ADDR_W (ADDR_W),
      .SEG_W  (SEG_W),
      .UNLK_A1(UNLK_A1),
      .UNLK_A2(UNLK_A2)
   ) u_cmd (
      .op      (op_q),
      .step    (step),
      .tgt     (tgt),
      .pdata   (buf_data),
      .cmd_addr(cmd_addr),
      .cmd_data(cmd_data),
      .cmd_last(cmd_last)
   );

   assign gap_load = (st == ST_CMD) && cmd_last;

   fps_gap_timer #(.CYC(RECOV_CYC)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (gap_load),
      .expired(gap_expired)
   );

   fps_poll_judge u_judge (
      .op     (op_q),
      .pdata  (buf_data),
      .rdata  (bus_rdata),
      .bit7_ok(bit7_ok),
      .byte_ok(byte_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         op_q     <= OP_PROG;
         tgt      <= '0;
         idx      <= '0;
         len_q    <= '0;
         step     <= '0;
         confirm  <= 1'b0;
         poll_cnt <= '0;
         err_v    <= 1'b0;
         err_t    <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start && op_ok) begin
                  op_q  <= op_e'(op);
                  tgt   <= base_addr;
                  idx   <= '0;
                  len_q <= len_m1;
                  step  <= '0;
                  err_v <= 1'b0;
                  err_t <= 1'b0;
                  st    <= ST_CMD;
               end
            end
            ST_CMD: begin
               if (cmd_last) begin
                  step     <= '0;
                  confirm  <= 1'b0;
                  poll_cnt <= '0;
                  st       <= ST_GAP;
               end else begin
                  step <= step + 3'd1;
               end
            end
            ST_GAP: begin
               if (gap_expired) st <= ST_RD;
            end
            ST_RD: st <= ST_RW;
            ST_RW: begin
               if (!confirm) begin
                  if (bit7_ok) begin
                     confirm <= 1'b1;
                     st      <= ST_RD;
                  end else if (poll_cnt == PC_W'(POLL_MAX - 1)) begin
                     err_t <= 1'b1;
                     st    <= ST_FIN;
                  end else begin
                     poll_cnt <= poll_cnt + PC_W'(1);
                     st       <= ST_RD;
                  end
               end else if (!byte_ok) begin
                  err_v <= 1'b1;
                  st    <= ST_FIN;
               end else if (op_q == OP_PROG && idx != len_q) begin
                  idx <= idx + LEN_W'(1);
                  tgt <= tgt + ADDR_W'(1);
                  st  <= ST_CMD;
               end else begin
                  st <= ST_FIN;
               end
            end
            ST_FIN: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (st != ST_IDLE);
   assign done        = (st == ST_FIN);
   assign bus_wr      = (st == ST_CMD);
   assign bus_rd      = (st == ST_RD);
   assign bus_addr    = (st == ST_CMD) ? cmd_addr : tgt;
   assign bus_wdata   = (st == ST_CMD) ? cmd_data : 8'h00;
   assign buf_idx     = idx;
   assign err_verify  = err_v;
   assign err_timeout = err_t;

   // R2: a command burst runs back to back until its final write
   p_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !cmd_last) |=> bus_wr);

   // R4: strobes never overlap
   p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   // R5: consecutive polls of one location keep the address
   p_poll_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && $past(bus_rd, 2)) |-> (bus_addr == $past(bus_addr, 2)));

   // R6: a read strobe is followed by a data cycle without strobes
   p_rd_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> (!bus_rd && !bus_wr));

   // R7: at most one error kind is reported
   p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_verify, err_timeout}));

   // R9: the poll count never exceeds its limit
   p_poll_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      poll_cnt < PC_W'(POLL_MAX));

   // R10: done is a single pulse that returns to idle
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R10: flags hold while idle without a start
   p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(err_verify) && $stable(err_timeout)));

endmodule

// File: tb/test_flash_poll_seq.sv
module test_flash_poll_seq;
   import fps_pkg::*;

   localparam int AW   = 24;
   localparam int SW   = 19;
   localparam int LW   = 4;
   localparam int RC   = 20;
   localparam int PM   = 6;
   localparam int BUSY = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          start = 1'b0;
   logic [1:0]    op = 2'd0;
   logic [AW-1:0] base = '0;
   logic [LW-1:0] len_m1 = '0;
   logic [LW-1:0] buf_idx;
   logic [7:0]    buf_data;
   logic          busy, done, err_v, err_t, bus_wr, bus_rd;
   logic [AW-1:0] bus_addr;
   logic [7:0]    bus_wdata;
   logic [7:0]    bus_rdata;
   logic [7:0]    seed = 8'h00;

   function automatic logic [7:0] pat(input logic [7:0] s, input int i);
      return s ^ 8'(i * 37 + 5);
   endfunction

   assign buf_data = pat(seed, int'(buf_idx));

   flash_poll_seq #(
      .ADDR_W(AW), .SEG_W(SW), .LEN_W(LW), .RECOV_CYC(RC), .POLL_MAX(PM)
   ) i_flash_poll_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_addr(base),
      .len_m1(len_m1), .buf_idx(buf_idx), .buf_data(buf_data), .busy(busy),
      .done(done), .err_verify(err_v), .err_timeout(err_t), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   int  n_chk = 0;
   int  n_bad = 0;
   bit  ended = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint got, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   // ---------------- responder: scaled flash segment ----------------
   logic [7:0] mem [256];
   int         mode;
   int         left;
   bit         early;
   logic [7:0] fin;
   logic       pb7;
   logic [7:0] h0, h1, h2, h3, h4;
   bit         stuck = 1'b0, bad = 1'b0, rclr = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
         mode <= 0; left <= 0; early <= 1'b0; fin <= 8'hFF; pb7 <= 1'b0;
         h0 <= 8'h00; h1 <= 8'h00; h2 <= 8'h00; h3 <= 8'h00; h4 <= 8'h00;
         bus_rdata <= 8'h00;
      end else begin
         if (rclr) mode <= 0;
         if (bus_wr) begin
            h0 <= bus_wdata; h1 <= h0; h2 <= h1; h3 <= h2; h4 <= h3;
            if (mode == 0 && h2 == 8'hAA && h1 == 8'h55 && h0 == 8'hA0) begin
               mode  <= 1;
               fin   <= (mem[bus_addr[7:0]] & bus_wdata) ^ (bad ? 8'h01 : 8'h00);
               pb7   <= bus_wdata[7];
               left  <= BUSY;
               early <= 1'b0;
            end else if (mode == 0 && h4 == 8'hAA && h3 == 8'h55 && h2 == 8'h80 &&
                         h1 == 8'hAA && h0 == 8'h55 &&
                         (bus_wdata == 8'h30 || bus_wdata == 8'h10)) begin
               mode  <= 2;
               fin   <= bad ? 8'hFE : 8'hFF;
               left  <= BUSY;
               early <= 1'b0;
            end
         end
         if (bus_rd) begin
            if (mode == 0) begin
               bus_rdata <= mem[bus_addr[7:0]];
            end else if (left > 0 || stuck) begin
               bus_rdata <= (mode == 1) ? {~pb7, 7'h2A} : 8'h00;
               if (left > 0) left <= left - 1;
            end else if (!early) begin
               bus_rdata <= {fin[7], ~fin[6:0]};
               early     <= 1'b1;
            end else begin
               bus_rdata <= fin;
               if (mode == 1) mem[bus_addr[7:0]] <= fin;
               else for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
               mode <= 0;
            end
         end
      end
   end

   // ---------------- reference expectations, checked every cycle ----------------
   logic [AW+8:0] wq [$];
   logic [AW-1:0] exp_rd = '0;
   string         cur_req = "R2";
   int            cyc = 0, last_wr = 0, last_rd = 0, reads = 0;
   bit            rd_after_wr = 1'b1;
   bit            armed = 1'b0, done_seen = 1'b0, exp_ev = 1'b0, exp_et = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         logic [AW+8:0] e;
         cyc++;
         if (bus_wr && bus_rd) chk(1'b0, "R4", "write and read together", 1, 0);
         if (bus_wr) begin
            if (wq.size() == 0) begin
               chk(1'b0, "R11", "unexpected write", longint'(bus_addr), 0);
            end else begin
               e = wq.pop_front();
               chk({bus_addr, bus_wdata} == e[AW+7:0], cur_req, "write addr/data",
                   longint'({bus_addr, bus_wdata}), longint'(e[AW+7:0]));
               if (e[AW+8]) exp_rd = e[AW+7:8];
            end
            last_wr     = cyc;
            rd_after_wr = 1'b0;
         end
         if (bus_rd) begin
            chk(bus_addr == exp_rd, "R5", "poll address", longint'(bus_addr), longint'(exp_rd));
            if (!rd_after_wr)
               chk(cyc - last_wr == RC + 2, "R4", "write-to-read gap", cyc - last_wr, RC + 2);
            else if (reads > 0 && last_rd > last_wr)
               chk(cyc - last_rd == 2, "R6", "re-poll spacing", cyc - last_rd, 2);
            rd_after_wr = 1'b1;
            reads++;
            last_rd = cyc;
         end
         if (done) begin
            if (!armed) begin
               chk(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
               chk(cyc - last_rd == 2, "R10", "done after last read", cyc - last_rd, 2);
               chk(busy, "R10", "busy during done", busy, 1);
               chk(err_v == exp_ev, "R7", "verify flag", err_v, exp_ev);
               chk(err_t == exp_et, "R9", "timeout flag", err_t, exp_et);
            end
            armed     = 1'b0;
            done_seen = 1'b1;
         end
      end
   end

   function automatic logic [AW-1:0] segb(input logic [AW-1:0] a);
      return {a[AW-1:SW], SW'(0)};
   endfunction

   task automatic push(input bit d, input logic [AW-1:0] a, input logic [7:0] v);
      wq.push_back({d, a, v});
   endtask

   task automatic run_op(input logic [1:0] o, input logic [AW-1:0] b, input int nm1,
                         input bit f_stuck, input bit f_bad, input int exp_reads,
                         input bit ev, input bit et, input bit poke, input string req);
      int n;
      if (o == 2'd0) begin
         for (int i = 0; i <= nm1; i++) begin
            logic [AW-1:0] t;
            t = b + AW'(i);
            push(1'b0, segb(t) | 24'h00AAAA, 8'hAA);
            push(1'b0, segb(t) | 24'h005554, 8'h55);
            push(1'b0, segb(t) | 24'h00AAAA, 8'hA0);
            push(1'b1, t, pat(seed, i));
         end
      end else begin
         push(1'b0, segb(b) | 24'h00AAAA, 8'hAA);
         push(1'b0, segb(b) | 24'h005554, 8'h55);
         push(1'b0, segb(b) | 24'h00AAAA, 8'h80);
         push(1'b0, segb(b) | 24'h00AAAA, 8'hAA);
         push(1'b0, segb(b) | 24'h005554, 8'h55);
         if (o == 2'd1) push(1'b0, b, 8'h30);
         else           push(1'b0, segb(b) | 24'h00AAAA, 8'h10);
      end
      @(negedge clk);
      stuck = f_stuck; bad = f_bad; rclr = 1'b1;
      op = o; base = b; len_m1 = LW'(nm1); start = 1'b1;
      exp_rd = b; reads = 0; exp_ev = ev; exp_et = et;
      armed = 1'b1; done_seen = 1'b0; cur_req = req;
      @(negedge clk);
      start = 1'b0; rclr = 1'b0;
      chk(busy, "R10", "busy after start", busy, 1);
      chk(!err_v && !err_t, "R10", "flags cleared by start", {err_v, err_t}, 0);
      if (poke) begin
         repeat (6) @(negedge clk);
         op = 2'd1; start = 1'b1;     // R11: ignored while busy
         @(negedge clk);
         start = 1'b0;
      end
      n = 0;
      while (!done_seen && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(done_seen, req, "operation finished", done_seen, 1);
      chk(reads == exp_reads, (et ? "R9" : "R6"), "poll read count", reads, exp_reads);
      chk(wq.size() == 0, req, "all writes issued", wq.size(), 0);
      wq.delete();
      repeat (4) @(negedge clk);
      chk(!busy, "R10", "idle after done", busy, 0);
      chk(err_v == ev && err_t == et, "R10", "flags held", {err_v, err_t}, {ev, et});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got expired expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk({busy, done, bus_wr, bus_rd, err_v, err_t} == 6'b0, "R1", "reset outputs",
          {busy, done, bus_wr, bus_rd, err_v, err_t}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, bus_wr, bus_rd} == 4'b0, "R1", "idle after reset",
          {busy, done, bus_wr, bus_rd}, 0);

      // R2 R6 R7: single byte program
      seed = 8'h11;
      run_op(2'd0, 24'h12_3410, 0, 1'b0, 1'b0, BUSY + 2, 1'b0, 1'b0, 1'b0, "R2");
      // R8 R11: five bytes, other segment, bit 7 of the data varies, start poked while busy
      seed = 8'h80;
      run_op(2'd0, 24'h0A_0020, 4, 1'b0, 1'b0, 5 * (BUSY + 2), 1'b0, 1'b0, 1'b1, "R8");
      // R3: sector erase then segment erase
      run_op(2'd1, 24'h05_0033, 0, 1'b0, 1'b0, BUSY + 2, 1'b0, 1'b0, 1'b0, "R3");
      run_op(2'd2, 24'h1F_0011, 0, 1'b0, 1'b0, BUSY + 2, 1'b0, 1'b0, 1'b0, "R3");
      // R7: program whose settled byte differs
      seed = 8'h5A;
      run_op(2'd0, 24'h00_0040, 0, 1'b0, 1'b1, BUSY + 2, 1'b1, 1'b0, 1'b0, "R7");
      // R9: program that never completes
      seed = 8'h27;
      run_op(2'd0, 24'h00_0050, 0, 1'b1, 1'b0, PM, 1'b0, 1'b1, 1'b0, "R9");
      // R9: erase that never completes
      run_op(2'd1, 24'h02_0060, 0, 1'b1, 1'b0, PM, 1'b0, 1'b1, 1'b0, "R9");
      // R7: erase whose settled byte is not FFh
      run_op(2'd2, 24'h03_0070, 0, 1'b0, 1'b1, BUSY + 2, 1'b1, 1'b0, 1'b0, "R7");

      // R11: reserved op code is ignored
      @(negedge clk);
      op = 2'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!busy, "R11", "reserved op ignored", busy, 0);
      repeat (4) @(negedge clk);
      chk(!busy && err_v, "R11", "state kept after reserved op", {busy, err_v}, 1);

      // R10: next good program clears flags and completes
      seed = 8'hC3;
      run_op(2'd0, 24'h00_0080, 1, 1'b0, 1'b0, 2 * (BUSY + 2), 1'b0, 1'b0, 1'b0, "R8");

      if (!ended) begin
         ended = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule